// File: doc/BRIEF.md
# Privilege Level Exception Router

This block keeps the current privilege level of a processor core, from 0 (least privileged) to 3 (most privileged). Each cycle it looks at a synchronous exception request, three asynchronous interrupt lines (normal interrupt, fast interrupt and system error) and an exception-return request. It decides whether an exception is taken and, if so, which level handles it and whether the handler runs wide or narrow. Levels 2 and 3 are each optional and are chosen by parameters. The block never sets a level that the build does not have.

Routing comes from two control words. The level-3 word is checked first and the level-2 word second. Each word holds one route bit per interrupt type and one width bit. The resolved target is folded onto the levels that exist, and it is never allowed to be level 0 or to fall below the current level. Each level has one interrupt mask bit. An interrupt taken to a level sets that level's mask, and a legal return clears the mask of the level being left. The new level, the taken pulse, the width and the masks are all registered, so they appear one clock edge after the request.

Top module: `plx_router`

## Requirements
- R1: After reset the level is the highest one implemented (3, else 2, else 1). `taken` and `eret_bad` are 0, all four mask bits are 0, and `hdl_wide` is 1.
- R2: A synchronous request is taken at the current level, or at level 1 when the current level is 0. `taken` is high for exactly the one cycle after the request.
- R3: Bit positions in both control words are: interrupt bit 0, fast interrupt bit 1, system error bit 2, width bit 3. For an interrupt, a set bit in the level-3 word routes it to 3. Otherwise a set bit in the level-2 word routes it to 2. Otherwise it goes to the current level, or to 1 when the current level is 0.
- R4: A taken exception never lands at level 0 and never below the level held before it.
- R5: A route to a level that is not implemented falls back to the highest implemented level at or below it. The result is never below level 1.
- R6: `hdl_wide` is set by the width bit of the word owned by the nearest implemented level above the target. A level-3 target is always wide. The value is held until the next taken exception.
- R7: An interrupt that is taken sets the mask bit of its target level. An interrupt whose type is requested while the current level's mask bit is set is ignored, whatever its routing. A synchronous request is never masked and never changes the masks.
- R8: When several requests are present in one cycle, only one is taken, in the order synchronous, system error, fast interrupt, normal interrupt.
- R9: A return whose target is at or below the current level and is implemented moves to that level and clears the mask bit of the level it leaves. Any other return changes nothing and raises `eret_bad` for one cycle.
- R10: If an exception is taken in the same cycle as a return request, the return is dropped and does not flag `eret_bad`.
- R11: The level rises only in a cycle where `taken` is high. It falls only to the target of the return requested in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_req | input | 1 | Synchronous exception request |
| irq_req | input | 1 | Normal interrupt request |
| fiq_req | input | 1 | Fast interrupt request |
| serr_req | input | 1 | System error request |
| eret_req | input | 1 | Exception-return request |
| eret_lvl | input | 2 | Level requested by the return |
| l3_route | input | 4 | Level-3 routing word: route bits [2:0], width bit [3] |
| l2_route | input | 4 | Level-2 routing word: route bits [2:0], width bit [3] |
| cur_lvl | output | 2 | Current privilege level |
| taken | output | 1 | One-cycle pulse: an exception was taken |
| hdl_wide | output | 1 | Handler execution width, 1 = wide |
| eret_bad | output | 1 | One-cycle pulse: a return request was refused |
| lvl_mask | output | 4 | Interrupt mask bit per level, bit n for level n |

## Verification
The properties assume that an edge arrives while reset is low, so that every history value seen afterwards was produced by reset. They also assume the default build, where every return target is an implemented level. The stimulus holds each request for a single cycle and changes it only at the falling edge. The routing words are applied together with the request they steer. A build with level 3 left out is driven only through the directed fallback steps, after a fresh reset.

// File: rtl/plx_pkg.sv
package plx_pkg;
  typedef logic [1:0] lvl_t;

  typedef enum logic [1:0] {
    CAUSE_SYNC = 2'd0,
    CAUSE_SERR = 2'd1,
    CAUSE_FIQ  = 2'd2,
    CAUSE_IRQ  = 2'd3
  } cause_e;

  localparam int NLVL    = 4;
  localparam int NASYNC  = 3;
  localparam int RT_IRQ  = 0;
  localparam int RT_FIQ  = 1;
  localparam int RT_SERR = 2;
  localparam int RT_WIDE = 3;
  localparam int RT_W    = 4;
endpackage

// File: rtl/plx_arb.sv
module plx_arb
  import plx_pkg::*;
(
  input  logic   sync_req,
  input  logic   serr_req,
  input  logic   fiq_req,
  input  logic   irq_req,
  input  logic   cur_masked,
  output logic   take,
  output logic   is_async,
  output cause_e cause
);
  logic [NASYNC-1:0] areq;
  logic [NASYNC-1:0] agate;
  cause_e            acode [NASYNC];

  // index 0 lowest priority, highest index wins
  assign areq     = {serr_req, fiq_req, irq_req};
  assign acode[0] = CAUSE_IRQ;
  assign acode[1] = CAUSE_FIQ;
  assign acode[2] = CAUSE_SERR;

  for (genvar g = 0; g < NASYNC; g++) begin : g_gate
    assign agate[g] = areq[g] & ~cur_masked;
  end

  always_comb begin
    cause    = CAUSE_SYNC;
    is_async = 1'b0;
    for (int i = 0; i < NASYNC; i++) begin
      if (agate[i]) begin
        cause    = acode[i];
        is_async = 1'b1;
      end
    end
    if (sync_req) begin
      cause    = CAUSE_SYNC;
      is_async = 1'b0;
    end
  end

  assign take = sync_req | (|agate);
endmodule

// File: rtl/plx_target.sv
module plx_target
  import plx_pkg::*;
#(
  parameter bit IMPL_L2 = 1'b1,
  parameter bit IMPL_L3 = 1'b1
) (
  input  cause_e          cause,
  input  lvl_t            cur,
  input  logic [RT_W-1:0] l3_route,
  input  logic [RT_W-1:0] l2_route,
  output lvl_t            tgt,
  output logic            wide
);
  int   rbit;
  lvl_t floor1;
  lvl_t raw;
  lvl_t folded;

  assign floor1 = (cur == 2'd0) ? 2'd1 : cur;

  always_comb begin
    unique case (cause)
      CAUSE_IRQ:  rbit = RT_IRQ;
      CAUSE_FIQ:  rbit = RT_FIQ;
      CAUSE_SERR: rbit = RT_SERR;
      default:    rbit = RT_IRQ;
    endcase
  end

  always_comb begin
    if (cause == CAUSE_SYNC)    raw = floor1;
    else if (l3_route[rbit])    raw = 2'd3;
    else if (l2_route[rbit])    raw = 2'd2;
    else                        raw = floor1;
  end

  always_comb begin
    folded = raw;
    if (folded == 2'd3 && !IMPL_L3) folded = 2'd2;
    if (folded == 2'd2 && !IMPL_L2) folded = 2'd1;
    if (folded < cur)               folded = cur;
    tgt = folded;
  end

  always_comb begin
    unique case (tgt)
      2'd3:    wide = 1'b1;
      2'd2:    wide = IMPL_L3 ? l3_route[RT_WIDE] : 1'b1;
      2'd1:    wide = IMPL_L2 ? l2_route[RT_WIDE]
                              : (IMPL_L3 ? l3_route[RT_WIDE] : 1'b1);
      default: wide = 1'b1;
    endcase
  end
endmodule

// File: rtl/plx_state.sv
module plx_state
  import plx_pkg::*;
#(
  parameter bit IMPL_L2 = 1'b1,
  parameter bit IMPL_L3 = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            is_async,
  input  lvl_t            tgt,
  input  logic            wide_in,
  input  logic            eret_req,
  input  lvl_t            eret_lvl,
  output lvl_t            cur_lvl,
  output logic            taken,
  output logic            hdl_wide,
  output logic            eret_bad,
  output logic [NLVL-1:0] lvl_mask
);
  localparam lvl_t RST_LVL = IMPL_L3 ? 2'd3 : (IMPL_L2 ? 2'd2 : 2'd1);

  lvl_t            cur_q,  cur_n;
  logic            tk_q,   tk_n;
  logic            wide_q, wide_n;
  logic            bad_q,  bad_n;
  logic [NLVL-1:0] mask_q, mask_n;
  logic            ret_impl;
  logic            ret_ok;
  logic            ret_go;
  logic            lvl_en;

  always_comb begin
    unique case (eret_lvl)
      2'd3:    ret_impl = IMPL_L3;
      2'd2:    ret_impl = IMPL_L2;
      default: ret_impl = 1'b1;
    endcase
  end

  assign ret_ok = ret_impl && (eret_lvl <= cur_q);
  assign ret_go = !take && eret_req && ret_ok;
  assign lvl_en = take | ret_go;

  always_comb begin
    cur_n  = cur_q;
    wide_n = wide_q;
    if (take) begin
      cur_n  = tgt;
      wide_n = wide_in;
    end else if (ret_go) begin
      cur_n  = eret_lvl;
    end
  end

  assign tk_n  = take;
  assign bad_n = !take && eret_req && !ret_ok;

  for (genvar g = 0; g < NLVL; g++) begin : g_mask
    assign mask_n[g] = (take && is_async && tgt == lvl_t'(g)) ? 1'b1 :
                       (ret_go && cur_q == lvl_t'(g))         ? 1'b0 :
                                                                mask_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= RST_LVL;
      wide_q <= 1'b1;
      mask_q <= '0;
    end else if (lvl_en) begin
      cur_q  <= cur_n;
      wide_q <= wide_n;
      mask_q <= mask_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tk_q  <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      tk_q  <= tk_n;
      bad_q <= bad_n;
    end
  end

  assign cur_lvl  = cur_q;
  assign taken    = tk_q;
  assign hdl_wide = wide_q;
  assign eret_bad = bad_q;
  assign lvl_mask = mask_q;
endmodule

// File: rtl/plx_router.sv
module plx_router
  import plx_pkg::*;
#(
  parameter bit IMPL_L2 = 1'b1,
  parameter bit IMPL_L3 = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_req,
  input  logic        irq_req,
  input  logic        fiq_req,
  input  logic        serr_req,
  input  logic        eret_req,
  input  logic [1:0]  eret_lvl,
  input  logic [3:0]  l3_route,
  input  logic [3:0]  l2_route,
  output logic [1:0]  cur_lvl,
  output logic        taken,
  output logic        hdl_wide,
  output logic        eret_bad,
  output logic [3:0]  lvl_mask
);
  logic [1:0] rs_q;
  logic       rst_n_s;
  logic       take;
  logic       is_async;
  cause_e     cause;
  lvl_t       tgt;
  logic       wide;
  logic       cur_masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  assign cur_masked = lvl_mask[cur_lvl];

  plx_arb u_arb (
    .sync_req   (sync_req),
    .serr_req   (serr_req),
    .fiq_req    (fiq_req),
    .irq_req    (irq_req),
    .cur_masked (cur_masked),
    .take       (take),
    .is_async   (is_async),
    .cause      (cause)
  );

  plx_target #(.IMPL_L2(IMPL_L2), .IMPL_L3(IMPL_L3)) u_tgt (
    .cause    (cause),
    .cur      (cur_lvl),
    .l3_route (l3_route),
    .l2_route (l2_route),
    .tgt      (tgt),
    .wide     (wide)
  );

  plx_state #(.IMPL_L2(IMPL_L2), .IMPL_L3(IMPL_L3)) u_st (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .take     (take),
    .is_async (is_async),
    .tgt      (tgt),
    .wide_in  (wide),
    .eret_req (eret_req),
    .eret_lvl (eret_lvl),
    .cur_lvl  (cur_lvl),
    .taken    (taken),
    .hdl_wide (hdl_wide),
    .eret_bad (eret_bad),
    .lvl_mask (lvl_mask)
  );
endmodule

// File: rtl/plx_router_chk.sv
module plx_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_req,
  input logic       eret_req,
  input logic [1:0] eret_lvl,
  input logic [1:0] cur_lvl,
  input logic       taken,
  input logic       eret_bad,
  input logic [3:0] lvl_mask
);
  a_r11_rise_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl > $past(cur_lvl)) |-> taken);

  a_r11_fall_needs_return: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl < $past(cur_lvl)) |-> ($past(eret_req) && cur_lvl == $past(eret_lvl)));

  a_r4_never_down_or_zero: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (cur_lvl != 2'd0 && cur_lvl >= $past(cur_lvl)));

  a_r2_sync_target: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && $past(sync_req)) |->
      (cur_lvl == (($past(cur_lvl) == 2'd0) ? 2'd1 : $past(cur_lvl))));

  a_r7_async_sets_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !$past(sync_req)) |-> lvl_mask[cur_lvl]);

  a_r9_refused_return_inert: assert property (@(posedge clk) disable iff (!rst_n)
    eret_bad |-> ($stable(cur_lvl) && $stable(lvl_mask)));

  a_r10_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({taken, eret_bad}));
endmodule

bind plx_router plx_router_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sync_req (sync_req),
  .eret_req (eret_req),
  .eret_lvl (eret_lvl),
  .cur_lvl  (cur_lvl),
  .taken    (taken),
  .eret_bad (eret_bad),
  .lvl_mask (lvl_mask)
);

// File: tb/sim_plx_router.sv
module sim_plx_router;
  localparam int CLK_NS = 10;
  localparam int NVEC   = 24;

  // {id[4], req{sync,serr,fiq,irq}[4], ret, ret_lvl[2], l3[4], l2[4],
  //  exp_cur[2], exp_taken, exp_wide, exp_bad, exp_mask[4]}
  localparam logic [27:0] VEC [0:NVEC-1] = '{
    {4'd9,  4'b0000, 1'b1, 2'd1, 4'h0, 4'h0, 2'd1, 1'b0, 1'b1, 1'b0, 4'b0000}, // R9 3->1
    {4'd11, 4'b0000, 1'b1, 2'd0, 4'h0, 4'h0, 2'd0, 1'b0, 1'b1, 1'b0, 4'b0000}, // R11 fall
    {4'd2,  4'b1000, 1'b0, 2'd0, 4'h0, 4'h8, 2'd1, 1'b1, 1'b1, 1'b0, 4'b0000}, // R2 0->1
    {4'd9,  4'b0000, 1'b1, 2'd0, 4'h0, 4'h0, 2'd0, 1'b0, 1'b1, 1'b0, 4'b0000}, // R2 pulse ends
    {4'd6,  4'b1000, 1'b0, 2'd0, 4'h0, 4'h0, 2'd1, 1'b1, 1'b0, 1'b0, 4'b0000}, // R6 narrow
    {4'd9,  4'b0000, 1'b1, 2'd0, 4'h0, 4'h0, 2'd0, 1'b0, 1'b0, 1'b0, 4'b0000},
    {4'd3,  4'b0001, 1'b0, 2'd0, 4'h0, 4'h1, 2'd2, 1'b1, 1'b0, 1'b0, 4'b0100}, // R3 irq->2
    {4'd7,  4'b0001, 1'b0, 2'd0, 4'h0, 4'h0, 2'd2, 1'b0, 1'b0, 1'b0, 4'b0100}, // R7 masked
    {4'd7,  4'b1000, 1'b0, 2'd0, 4'h8, 4'h0, 2'd2, 1'b1, 1'b1, 1'b0, 4'b0100}, // R7 sync passes
    {4'd9,  4'b0000, 1'b1, 2'd3, 4'h0, 4'h0, 2'd2, 1'b0, 1'b1, 1'b1, 4'b0100}, // R9 refused
    {4'd11, 4'b0000, 1'b1, 2'd0, 4'h0, 4'h0, 2'd0, 1'b0, 1'b1, 1'b0, 4'b0000}, // R11 fall
    {4'd6,  4'b0010, 1'b0, 2'd0, 4'h2, 4'h0, 2'd3, 1'b1, 1'b1, 1'b0, 4'b1000}, // R6 lvl3 wide
    {4'd9,  4'b0000, 1'b1, 2'd0, 4'h0, 4'h0, 2'd0, 1'b0, 1'b1, 1'b0, 4'b0000},
    {4'd8,  4'b1100, 1'b0, 2'd0, 4'h4, 4'h8, 2'd1, 1'b1, 1'b1, 1'b0, 4'b0000}, // R8 sync>serr
    {4'd8,  4'b0110, 1'b0, 2'd0, 4'h2, 4'h4, 2'd2, 1'b1, 1'b0, 1'b0, 4'b0100}, // R8 serr>fiq
    {4'd9,  4'b0000, 1'b1, 2'd0, 4'h0, 4'h0, 2'd0, 1'b0, 1'b0, 1'b0, 4'b0000},
    {4'd4,  4'b0011, 1'b0, 2'd0, 4'h0, 4'h1, 2'd1, 1'b1, 1'b0, 1'b0, 4'b0010}, // R4/R8 fiq>irq
    {4'd7,  4'b0001, 1'b0, 2'd0, 4'h1, 4'h0, 2'd1, 1'b0, 1'b0, 1'b0, 4'b0010}, // R7 masked
    {4'd10, 4'b1000, 1'b1, 2'd0, 4'h0, 4'h0, 2'd1, 1'b1, 1'b0, 1'b0, 4'b0010}, // R10
    {4'd9,  4'b0000, 1'b1, 2'd0, 4'h0, 4'h0, 2'd0, 1'b0, 1'b0, 1'b0, 4'b0000},
    {4'd3,  4'b0001, 1'b0, 2'd0, 4'h0, 4'h1, 2'd2, 1'b1, 1'b0, 1'b0, 4'b0100}, // R3
    {4'd9,  4'b0000, 1'b1, 2'd2, 4'h0, 4'h0, 2'd2, 1'b0, 1'b0, 1'b0, 4'b0000}, // R9 same lvl
    {4'd4,  4'b0010, 1'b0, 2'd0, 4'h8, 4'h0, 2'd2, 1'b1, 1'b1, 1'b0, 4'b0100}, // R4 no drop
    {4'd7,  4'b0100, 1'b0, 2'd0, 4'h4, 4'h0, 2'd2, 1'b0, 1'b1, 1'b0, 4'b0100}  // R7 masked
  };

  logic       clk;
  logic       rst_n;
  logic       sync_req, irq_req, fiq_req, serr_req, eret_req;
  logic [1:0] eret_lvl;
  logic [3:0] l3_route, l2_route;
  logic [1:0] cur_lvl,  b_cur_lvl;
  logic       taken,    b_taken;
  logic       hdl_wide, b_hdl_wide;
  logic       eret_bad, b_eret_bad;
  logic [3:0] lvl_mask, b_lvl_mask;
  int         checks;
  int         errors;
  bit         done;

  plx_router u0 (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .irq_req(irq_req),
    .fiq_req(fiq_req), .serr_req(serr_req), .eret_req(eret_req),
    .eret_lvl(eret_lvl), .l3_route(l3_route), .l2_route(l2_route),
    .cur_lvl(cur_lvl), .taken(taken), .hdl_wide(hdl_wide),
    .eret_bad(eret_bad), .lvl_mask(lvl_mask)
  );

  plx_router #(.IMPL_L2(1'b1), .IMPL_L3(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .irq_req(irq_req),
    .fiq_req(fiq_req), .serr_req(serr_req), .eret_req(eret_req),
    .eret_lvl(eret_lvl), .l3_route(l3_route), .l2_route(l2_route),
    .cur_lvl(b_cur_lvl), .taken(b_taken), .hdl_wide(b_hdl_wide),
    .eret_bad(b_eret_bad), .lvl_mask(b_lvl_mask)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [3:0] rq, input logic ret, input logic [1:0] rl,
                       input logic [3:0] r3, input logic [3:0] r2);
    @(negedge clk);
    {sync_req, serr_req, fiq_req, irq_req} = rq;
    eret_req = ret;
    eret_lvl = rl;
    l3_route = r3;
    l2_route = r2;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    {sync_req, serr_req, fiq_req, irq_req, eret_req} = '0;
    eret_lvl = '0;
    l3_route = '0;
    l2_route = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    do_reset();

    // R1: reset state of both builds
    chk("R1 cur", cur_lvl, 3);
    chk("R1 taken", taken, 0);
    chk("R1 bad", eret_bad, 0);
    chk("R1 mask", lvl_mask, 0);
    chk("R1 wide", hdl_wide, 1);
    chk("R1 cur no-l3", b_cur_lvl, 2);

    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      string       tg;
      v  = VEC[i];
      tg = $sformatf("R%0d v%0d", v[27:24], i);
      apply(v[23:20], v[19], v[18:17], v[16:13], v[12:9]);
      chk({tg, " cur"},   cur_lvl,  v[8:7]);
      chk({tg, " taken"}, taken,    v[6]);
      chk({tg, " wide"},  hdl_wide, v[5]);
      chk({tg, " bad"},   eret_bad, v[4]);
      chk({tg, " mask"},  lvl_mask, v[3:0]);
    end

    // R5: fallback when level 3 is absent, routed via the level-3 irq bit (bit 0)
    do_reset();
    apply(4'b0000, 1'b1, 2'd0, 4'h0, 4'h0);
    chk("R9 u0 to 0", cur_lvl, 0);
    chk("R9 u1 to 0", b_cur_lvl, 0);
    apply(4'b0001, 1'b0, 2'd0, 4'h1, 4'h0);
    chk("R3 u0 irq to 3", cur_lvl, 3);
    chk("R3 u0 mask", lvl_mask, 4'b1000);
    chk("R5 u1 fold to 2", b_cur_lvl, 2);
    chk("R5 u1 mask", b_lvl_mask, 4'b0100);
    chk("R6 u1 wide no l3", b_hdl_wide, 1);
    apply(4'b1000, 1'b0, 2'd0, 4'h0, 4'h0);
    chk("R4 u0 sync at 3", cur_lvl, 3);
    chk("R2 u0 taken", taken, 1);
    chk("R4 u1 sync at 2", b_cur_lvl, 2);
    apply(4'b0000, 1'b1, 2'd3, 4'h0, 4'h0);
    chk("R9 u1 absent target", b_eret_bad, 1);
    chk("R9 u1 level kept", b_cur_lvl, 2);
    chk("R9 u0 return to 3 ok", eret_bad, 0);
    apply(4'b0000, 1'b0, 2'd0, 4'h0, 4'h0);
    chk("R9 bad one cycle", b_eret_bad, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      errors++;
      $display("FAIL all requirements: watchdog actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule